// File: doc/BRIEF.md
# USB Full-Speed Receive Bit Stepper

This block performs the whole per-bit receive step for a USB full-speed data stream in one clock. An outside sample strobe fires once per bit time, at the nominal middle of the bit, and on that cycle the block reads one pin of a selectable pin pair and its partner. It decodes the NRZI line state and detects the two single-ended line states. It drops stuffed bits, shifts data bits into a byte register and advances a running USB CRC16.

Software or a small sequencer picks the pin pair with a pin index. Before each packet it presets the CRC register. It then strobes the block at every bit centre and reads back the flags, the assembled byte and the CRC. Clock recovery, packet framing, PID checks and transmit live elsewhere.

Top module: `usb_fs_rx_step`

## Requirements
- R1: Under synchronous reset all status outputs are 0, `data_byte` is 0, `crc` is all ones, and the stored reference line level is 1.
- R2: On a strobe, `bit_out` is 1 when the selected pin reads the same level as at the previous strobe and 0 when it differs. The current level then becomes the reference for the next strobe.
- R3: The partner pin is the selected index with bit 0 inverted. Index 4 pairs with 5, and index 5 pairs with 4.
- R4: On a strobe, `se0` is set when both pins of the pair read 0, and `se1` is set when both read 1. The two are never set together.
- R5: Each data bit b advances the CRC as f = b XOR crc[0], then crc = (crc >> 1) XOR (f ? 0xA001 : 0). This is polynomial 0x8005 in bit-reversed form. `crc_load` presets the CRC from `crc_init` and wins over a same-cycle update. Without a strobe or a load the CRC holds. With preset 0xFFFF, the bytes 0x31 to 0x39 sent LSB first leave 0x4B37.
- R6: After six consecutive decoded 1 data bits, the next non-SE0 strobe is a stuffed bit. It does not reach the byte or the CRC, it raises `stuff_drop`, and it raises `stuff_err` when it decodes as 1. The ones run then restarts at 0.
- R7: Data bits enter the byte LSB first (new byte = {bit, byte[7:1]}). On the eighth data bit `byte_done` pulses, `data_byte` holds the complete byte, and the bit count restarts.
- R8: An SE0 strobe clears the ones run and the bit count and leaves `data_byte` and `crc` unchanged. An SE1 strobe is handled as a data bit.
- R9: The flag outputs show the result of a strobe in the cycle after it and are 0 in every cycle that follows no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Bit-centre strobe, one step per high cycle |
| pins | input | NUM_PINS | Sampled pin levels |
| pin_sel | input | SEL_W | Index of the pin to decode, partner is index XOR 1 |
| crc_load | input | 1 | Preset the CRC register |
| crc_init | input | CRC_W | Preset value for the CRC |
| bit_out | output | 1 | Decoded bit of the last strobe |
| se0 | output | 1 | Both pair pins were 0 |
| se1 | output | 1 | Both pair pins were 1 |
| stuff_drop | output | 1 | The last strobe was a dropped stuffed bit |
| byte_done | output | 1 | The last strobe completed a byte |
| stuff_err | output | 1 | The stuffed bit decoded as 1 |
| data_byte | output | BYTE_W | Byte assembly register |
| crc | output | CRC_W | Running CRC register |

## Verification
The bench builds the block with NUM_PINS = 6 and keeps the default 16-bit CRC, 8-bit byte and six-bit stuffing run. Six pins give a low pair, a middle pair and a top pair whose odd index 5 must pair downward with 4, so a wrong partner choice shows up as a false SE0 or SE1. The short run limit and the ones-biased random data reach stuffed bits, stuffing violations and SE0 in the middle of a byte within a few thousand strobes. A known nine-byte CRC result ties the CRC datapath to an absolute value.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

    typedef struct packed {
        logic level;
        logic partner;
    } pair_t;

    typedef struct packed {
        logic bit_val;
        logic se0;
        logic se1;
        logic is_data;
        logic stuffed;
        logic stuff_err;
    } dec_t;

    function automatic logic [31:0] reflect_bits(input logic [31:0] v, input int unsigned w);
        logic [31:0] r;
        r = '0;
        for (int unsigned i = 0; i < w; i++) begin
            r[w-1-i] = v[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/usbrx_pair_select.sv
module usbrx_pair_select #(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned SEL_W    = $clog2(NUM_PINS)
) (
    input  logic [NUM_PINS-1:0] pins,
    input  logic [SEL_W-1:0]    sel,
    output usbrx_pkg::pair_t    pair
);
    logic [SEL_W-1:0] partner_idx;

    assign partner_idx = sel ^ SEL_W'(1);

    always_comb begin
        pair = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (SEL_W'(i) == sel)         pair.level   = pins[i];
            if (SEL_W'(i) == partner_idx) pair.partner = pins[i];
        end
    end

    initial begin
        assert (NUM_PINS % 2 == 0) else $error("pin count must be even");
    end
endmodule

// File: rtl/usbrx_line_decoder.sv
module usbrx_line_decoder #(
    parameter int unsigned STUFF_RUN = 6,
    localparam int unsigned RUN_W    = $clog2(STUFF_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  usbrx_pkg::pair_t pair,
    output usbrx_pkg::dec_t  dec
);
    logic             ref_q;
    logic [RUN_W-1:0] run_q;
    logic             decoded;
    logic             at_limit;

    assign decoded  = (pair.level == ref_q);
    assign at_limit = (run_q == RUN_W'(STUFF_RUN));

    always_comb begin
        dec.bit_val   = decoded;
        dec.se0       = ~pair.level & ~pair.partner;
        dec.se1       = pair.level & pair.partner;
        dec.stuffed   = ~dec.se0 & at_limit;
        dec.is_data   = ~dec.se0 & ~at_limit;
        dec.stuff_err = dec.stuffed & decoded;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b1;
            run_q <= '0;
        end else if (strobe) begin
            ref_q <= pair.level;
            if (dec.se0 || dec.stuffed) begin
                run_q <= '0;
            end else if (decoded) begin
                run_q <= run_q + RUN_W'(1);
            end else begin
                run_q <= '0;
            end
        end
    end

    // R6: the ones run never passes the stuffing limit
    p_run_bound_r6: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_W'(STUFF_RUN));

    // R6: a stuffed step always restarts the run
    p_run_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (strobe && dec.stuffed) |=> (run_q == '0));
endmodule

// File: rtl/usbrx_accum.sv
module usbrx_accum #(
    parameter int unsigned CRC_W    = 16,
    parameter logic [31:0] CRC_POLY = 32'h0000_8005,
    parameter logic [31:0] CRC_RST  = 32'hFFFF_FFFF,
    parameter int unsigned BYTE_W   = 8,
    localparam int unsigned CNT_W   = $clog2(BYTE_W),
    localparam logic [CRC_W-1:0] POLY_R =
        CRC_W'(usbrx_pkg::reflect_bits(CRC_POLY, CRC_W))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  usbrx_pkg::dec_t   dec,
    input  logic              crc_load,
    input  logic [CRC_W-1:0]  crc_init,
    output logic [BYTE_W-1:0] data_byte,
    output logic [CRC_W-1:0]  crc,
    output logic              byte_done
);
    logic [BYTE_W-1:0] byte_q;
    logic [CRC_W-1:0]  crc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic              take;
    logic              fb;
    logic [CRC_W-1:0]  crc_nxt;

    assign take    = strobe & dec.is_data;
    assign fb      = dec.bit_val ^ crc_q[0];
    assign crc_nxt = (crc_q >> 1) ^ (fb ? POLY_R : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
            crc_q  <= CRC_W'(CRC_RST);
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (crc_load) begin
                crc_q <= crc_init;
            end else if (take) begin
                crc_q <= crc_nxt;
            end
            if (take) begin
                byte_q <= {dec.bit_val, byte_q[BYTE_W-1:1]};
                if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                    cnt_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end else if (strobe && dec.se0) begin
                cnt_q <= '0;
            end
        end
    end

    assign data_byte = byte_q;
    assign crc       = crc_q;
    assign byte_done = done_q;

    // R5: without a step or a preset the CRC holds
    p_crc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !crc_load) |=> $stable(crc_q));

    // R8: a step that carries no data leaves the byte untouched
    p_byte_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (strobe && !dec.is_data) |=> $stable(byte_q));

    // R7: the bit count stays inside one byte
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(BYTE_W - 1));
endmodule

// File: rtl/usb_fs_rx_step.sv
module usb_fs_rx_step #(
    parameter int unsigned NUM_PINS  = 8,
    parameter int unsigned SEL_W     = $clog2(NUM_PINS),
    parameter int unsigned CRC_W     = 16,
    parameter logic [31:0] CRC_POLY  = 32'h0000_8005,
    parameter logic [31:0] CRC_RST   = 32'hFFFF_FFFF,
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned STUFF_RUN = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_en,
    input  logic [NUM_PINS-1:0] pins,
    input  logic [SEL_W-1:0]    pin_sel,
    input  logic                crc_load,
    input  logic [CRC_W-1:0]    crc_init,
    output logic                bit_out,
    output logic                se0,
    output logic                se1,
    output logic                stuff_drop,
    output logic                byte_done,
    output logic                stuff_err,
    output logic [BYTE_W-1:0]   data_byte,
    output logic [CRC_W-1:0]    crc
);
    usbrx_pkg::pair_t pair;
    usbrx_pkg::dec_t  dec;

    logic bit_q, se0_q, se1_q, drop_q, err_q;

    usbrx_pair_select #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) i_pair (
        .pins (pins),
        .sel  (pin_sel),
        .pair (pair)
    );

    usbrx_line_decoder #(.STUFF_RUN(STUFF_RUN)) i_dec (
        .clk    (clk),
        .rst    (rst),
        .strobe (sample_en),
        .pair   (pair),
        .dec    (dec)
    );

    usbrx_accum #(
        .CRC_W    (CRC_W),
        .CRC_POLY (CRC_POLY),
        .CRC_RST  (CRC_RST),
        .BYTE_W   (BYTE_W)
    ) i_acc (
        .clk       (clk),
        .rst       (rst),
        .strobe    (sample_en),
        .dec       (dec),
        .crc_load  (crc_load),
        .crc_init  (crc_init),
        .data_byte (data_byte),
        .crc       (crc),
        .byte_done (byte_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q  <= 1'b0;
            se0_q  <= 1'b0;
            se1_q  <= 1'b0;
            drop_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            bit_q  <= sample_en & dec.bit_val;
            se0_q  <= sample_en & dec.se0;
            se1_q  <= sample_en & dec.se1;
            drop_q <= sample_en & dec.stuffed;
            err_q  <= sample_en & dec.stuff_err;
        end
    end

    assign bit_out    = bit_q;
    assign se0        = se0_q;
    assign se1        = se1_q;
    assign stuff_drop = drop_q;
    assign stuff_err  = err_q;

    // R4: the two single-ended states exclude each other
    p_se_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(se0 && se1));

    // R6: an error is only ever reported on a dropped bit
    p_err_on_drop_r6: assert property (@(posedge clk) disable iff (rst)
        stuff_err |-> stuff_drop);

    // R9: a completed byte always follows a strobe
    p_done_after_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> $past(sample_en));

    // R9: no flag is raised without a strobe one cycle before
    p_flags_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> !(bit_out || se0 || se1 || stuff_drop || byte_done));
endmodule

// File: tb/test_usb_fs_rx_step.sv
module test_usb_fs_rx_step;
    localparam int NP = 6;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sample_en = 1'b0;
    logic [NP-1:0] pins = '1;
    logic [SW-1:0] pin_sel = '0;
    logic          crc_load = 1'b0;
    logic [15:0]   crc_init = '0;
    logic          bit_out, se0, se1, stuff_drop, byte_done, stuff_err;
    logic [7:0]    data_byte;
    logic [15:0]   crc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // model state
    logic       m_ref = 1'b1;
    int         m_run = 0;
    int         m_cnt = 0;
    logic [7:0] m_byte = '0;
    logic [15:0] m_crc = 16'hFFFF;

    always #5 clk = ~clk;

    usb_fs_rx_step #(.NUM_PINS(NP), .SEL_W(SW)) i_usb_fs_rx_step (
        .clk(clk), .rst(rst), .sample_en(sample_en), .pins(pins),
        .pin_sel(pin_sel), .crc_load(crc_load), .crc_init(crc_init),
        .bit_out(bit_out), .se0(se0), .se1(se1), .stuff_drop(stuff_drop),
        .byte_done(byte_done), .stuff_err(stuff_err),
        .data_byte(data_byte), .crc(crc)
    );

    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
        logic [15:0] r;
        r = {1'b0, c[15:1]};
        if (b ^ c[0]) r = r ^ 16'hA001;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one strobe with explicit pin pair levels; other pins read ~prt
    task automatic strobe_line(input logic lvl, input logic prt, input logic ld,
                               input logic [15:0] init);
        logic e_bit, e_se0, e_se1, e_stf, e_err, e_done;
        pins = {NP{~prt}};
        pins[pin_sel] = lvl;
        pins[pin_sel ^ 3'd1] = prt;
        sample_en = 1'b1;
        crc_load = ld;
        crc_init = init;
        e_bit  = (lvl == m_ref);
        e_se0  = !lvl && !prt;
        e_se1  = lvl && prt;
        e_stf  = !e_se0 && (m_run == 6);
        e_err  = e_stf && e_bit;
        e_done = 1'b0;
        m_ref  = lvl;
        if (e_se0) begin
            m_run = 0;
            m_cnt = 0;
        end else if (e_stf) begin
            m_run = 0;
        end else begin
            m_run  = e_bit ? m_run + 1 : 0;
            m_byte = {e_bit, m_byte[7:1]};
            m_crc  = crc_bit(m_crc, e_bit);
            if (m_cnt == 7) begin
                m_cnt = 0;
                e_done = 1'b1;
            end else begin
                m_cnt++;
            end
        end
        if (ld) m_crc = init;
        @(posedge clk);
        @(negedge clk);
        sample_en = 1'b0;
        crc_load = 1'b0;
        chk("R2 bit_out", bit_out, e_bit);
        chk("R4 se0", se0, e_se0);
        chk("R4 se1", se1, e_se1);
        chk("R6 stuff_drop", stuff_drop, e_stf);
        chk("R6 stuff_err", stuff_err, e_err);
        chk("R7 byte_done", byte_done, e_done);
        chk("R7 data_byte", data_byte, m_byte);
        chk("R5 crc", crc, m_crc);
    endtask

    task automatic raw_bit(input logic d);
        logic lvl;
        lvl = d ? m_ref : ~m_ref;
        strobe_line(lvl, ~lvl, 1'b0, 16'h0);
    endtask

    task automatic data_bit(input logic d);
        if (m_run == 6) raw_bit(1'b0);
        raw_bit(d);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) data_bit(b[i]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R9 quiet flags", {bit_out, se0, se1, stuff_drop, byte_done, stuff_err}, 6'b0);
            chk("R5 crc hold", crc, m_crc);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] save_b;
        logic [15:0] save_c;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 data_byte", data_byte, 8'h00);
        chk("R1 crc", crc, 16'hFFFF);
        chk("R1 flags", {bit_out, se0, se1, stuff_drop, byte_done, stuff_err}, 6'b0);
        // R1 reference 1: a high line decodes as 1
        pin_sel = 3'd0;
        raw_bit(1'b1);
        chk("R1 reference level", bit_out, 1'b1);
        idle(3);

        // R5 known vector with preset
        strobe_line(1'b0, 1'b0, 1'b1, 16'hFFFF);   // SE0 step plus preset
        for (int k = 0; k < 9; k++) send_byte(8'h31 + 8'(k));
        chk("R5 known crc", crc, 16'h4B37);

        // R3 pairing on odd and even top pair
        pin_sel = 3'd5;
        strobe_line(1'b0, 1'b0, 1'b0, 16'h0);
        chk("R3 odd pair se0", se0, 1'b1);
        strobe_line(1'b1, 1'b1, 1'b0, 16'h0);
        chk("R3 odd pair se1", se1, 1'b1);
        pin_sel = 3'd4;
        strobe_line(1'b0, 1'b0, 1'b0, 16'h0);
        chk("R3 even pair se0", se0, 1'b1);

        // R6 legal stuffing then a violation
        pin_sel = 3'd2;
        for (int i = 0; i < 6; i++) raw_bit(1'b1);
        raw_bit(1'b0);
        chk("R6 stuffed zero dropped", stuff_drop, 1'b1);
        for (int i = 0; i < 6; i++) raw_bit(1'b1);
        raw_bit(1'b1);
        chk("R6 stuff error", stuff_err, 1'b1);

        // R8 SE0 in mid byte
        strobe_line(1'b0, 1'b0, 1'b0, 16'h0);
        for (int i = 0; i < 3; i++) data_bit(1'b0);
        save_b = data_byte;
        save_c = crc;
        strobe_line(1'b0, 1'b0, 1'b0, 16'h0);
        chk("R8 byte kept", data_byte, save_b);
        chk("R8 crc kept", crc, save_c);
        for (int i = 0; i < 7; i++) data_bit(1'b1);
        chk("R8 count cleared, no done yet", byte_done, 1'b0);
        data_bit(1'b0);
        chk("R7 done after eight", byte_done, 1'b1);

        // R5 preset wins over a same-cycle data step
        strobe_line(~m_ref, m_ref, 1'b1, 16'h1234);
        chk("R5 preset priority", crc, 16'h1234);
        idle(2);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            if (r < 3) begin
                pin_sel = SW'($urandom_range(0, NP - 1));
            end
            if (r < 6) begin
                strobe_line(1'b0, 1'b0, 1'b0, 16'h0);
            end else if (r < 9) begin
                strobe_line(1'b1, 1'b1, 1'b0, 16'h0);
            end else if (r < 13) begin
                raw_bit(1'($urandom_range(0, 1)));
            end else if (r < 15) begin
                idle(1);
            end else if (r < 16) begin
                strobe_line(~m_ref, m_ref, 1'b1, 16'($urandom));
            end else begin
                data_bit($urandom_range(0, 9) < 7);
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule